// File: doc/BRIEF.md
# Register File with Pointer-Based Indirect Access

This block is the 32-location, 8-bit data register file of a small accumulator-style core. It has one combinational read port and one synchronous write port, each addressed by a 5-bit file address. Several locations are special. Location 0 holds no data: any access to it is forwarded to the location named by a 5-bit pointer register. The status register guards its fixed bits and its arithmetic flags against ordinary writes. Locations that are not built read as zero and ignore writes.

The core's datapath drives the write port with a result and its destination. In the same cycle it drives a separate flag port carrying the Z, DC and C values and a per-bit update enable. Power-management logic drives the two fixed status bits through their own load port. The locations at 1, 2, 5 and 6 are plain storage bytes that hold the timer, PC low byte, calibration and port values. The pointer sits at 4, the status register at 3, and general-purpose RAM starts at 8. `NUM_GPR` sets how many RAM bytes exist.

Top module: `regfile_indirect`

## Requirements
- R1: A write to a plain location (1, 2, 5, 6) or to RAM (8 up to 8+NUM_GPR-1) is stored at the rising clock edge, and a read of that address returns the byte combinationally.
- R2: A read of the address being written in the same cycle returns the value held before the write.
- R3: An access to address 0 acts on the location whose address is held in the pointer. The pointer value used is the one before the write.
- R4: With the pointer equal to 0, a read of address 0 returns 00h, and a write to address 0 changes no location.
- R5: The pointer at address 4 keeps bits 4:0 of a written byte, and a read returns it with bits 7:5 set to 1.
- R6: The status register at address 3 takes bits 7:5 and 2:0 of a written byte when no flag update is enabled in that cycle.
- R7: Flag enables flag_we bit 2 (Z, status bit 2), bit 1 (DC, status bit 1) and bit 0 (C, status bit 0) load the matching flag_val bit. Whenever any enable is set, a status write does not touch bits 2:0. Example: clearing status gives 000uu1uu when only Z is enabled with value 1.
- R8: Status bits 4 (timeout) and 3 (power-down) ignore the write port. They change only when pwr_we is high, which loads pwr_val[1] into bit 4 and pwr_val[0] into bit 3.
- R9: Address 7 and the addresses from 8+NUM_GPR to 31 read 00h, and writes to them are ignored.
- R10: After reset, status reads 18h, the pointer reads E0h, and the plain locations read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 5 | Read address (0 = through pointer) |
| rd_data | output | 8 | Read data, combinational |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write address (0 = through pointer) |
| wr_data | input | 8 | Write data |
| flag_we | input | 3 | Flag update enables: bit2 Z, bit1 DC, bit0 C |
| flag_val | input | 3 | Flag values, same bit order |
| pwr_we | input | 1 | Load enable for status bits 4:3 |
| pwr_val | input | 2 | New timeout (bit 1) and power-down (bit 0) values |

## Verification
Two functions can act in the same cycle: a write whose destination is status, and a flag update from the ALU port. The bench provokes this by writing status with every combination of flag enable and flag value, with the write data varied. It compares the result with a bench model in which any enabled flag keeps all three flag bits away from the write data. The same overlap occurs when an indirect write through a pointer of 3 or 4 lands on status or on the pointer itself. A sweep over all 32 pointer values covers those cases.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_AW  = 5;
  localparam int RF_DW  = 8;
  localparam int FLAG_N = 3;

  localparam logic [RF_AW-1:0] ADR_IND  = 5'd0;
  localparam logic [RF_AW-1:0] ADR_STS  = 5'd3;
  localparam logic [RF_AW-1:0] ADR_PTR  = 5'd4;
  localparam int               PLAIN_A  = 1;
  localparam int               PLAIN_B  = 5;
  localparam int               PLAIN_N  = 2;
  localparam int               GPR_BASE = 8;

  // Forward address 0 through the pointer; other addresses pass through.
  function automatic logic [RF_AW-1:0] resolve_addr(
    input logic [RF_AW-1:0] addr,
    input logic [RF_AW-1:0] ptr
  );
    return (addr == ADR_IND) ? ptr : addr;
  endfunction
endpackage

// File: rtl/rf_store.sv
module rf_store
  import rf_pkg::*;
#(
  parameter int BASE  = 1,
  parameter int COUNT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [RF_AW-1:0] wr_addr,
  input  logic [RF_DW-1:0] wr_data,
  input  logic [RF_AW-1:0] rd_addr,
  output logic [RF_DW-1:0] rd_data
);
  logic [RF_DW-1:0] word_q [COUNT];

  for (genvar i = 0; i < COUNT; i++) begin : g_word
    localparam logic [RF_AW-1:0] MY_ADDR = RF_AW'(BASE + i);
    logic             we;
    logic [RF_DW-1:0] q;
    logic [RF_DW-1:0] nxt;

    always_comb begin
      we  = wr_en && (wr_addr == MY_ADDR);
      nxt = we ? wr_data : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we) q <= nxt;
    end

    assign word_q[i] = q;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < COUNT; i++) begin
      if (rd_addr == RF_AW'(BASE + i)) rd_data = word_q[i];
    end
  end
endmodule

// File: rtl/rf_status.sv
module rf_status
  import rf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [2:0]        wr_hi,
  input  logic [FLAG_N-1:0] wr_fl,
  input  logic [FLAG_N-1:0] flag_we,
  input  logic [FLAG_N-1:0] flag_val,
  input  logic              pwr_we,
  input  logic [1:0]        pwr_val,
  output logic [RF_DW-1:0]  q
);
  logic [RF_DW-1:0] nxt;
  logic             en;

  always_comb begin
    nxt = q;
    if (wr_hit) begin
      nxt[7:5] = wr_hi;
      if (flag_we == '0) nxt[FLAG_N-1:0] = wr_fl;
    end
    for (int i = 0; i < FLAG_N; i++) begin
      if (flag_we[i]) nxt[i] = flag_val[i];
    end
    if (pwr_we) nxt[4:3] = pwr_val;
    en = wr_hit || (flag_we != '0) || pwr_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 8'h18;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/rf_ptr.sv
module rf_ptr
  import rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [RF_AW-1:0] wr_val,
  output logic [RF_AW-1:0] q
);
  logic [RF_AW-1:0] nxt;

  always_comb nxt = wr_hit ? wr_val : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (wr_hit) q <= nxt;
  end
endmodule

// File: rtl/regfile_indirect.sv
module regfile_indirect
  import rf_pkg::*;
#(
  parameter int NUM_GPR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RF_AW-1:0]  rd_addr,
  output logic [RF_DW-1:0]  rd_data,
  input  logic              wr_en,
  input  logic [RF_AW-1:0]  wr_addr,
  input  logic [RF_DW-1:0]  wr_data,
  input  logic [FLAG_N-1:0] flag_we,
  input  logic [FLAG_N-1:0] flag_val,
  input  logic              pwr_we,
  input  logic [1:0]        pwr_val
);
  localparam int PTR_PAD = RF_DW - RF_AW;

  logic [RF_AW-1:0] ptr_q;
  logic [RF_DW-1:0] sts_q;
  logic [RF_AW-1:0] rd_eff, wr_eff;
  logic             wr_live;
  logic             sts_hit, ptr_hit;
  logic [RF_DW-1:0] lo_d, hi_d, gpr_d;

  always_comb begin
    rd_eff  = resolve_addr(rd_addr, ptr_q);
    wr_eff  = resolve_addr(wr_addr, ptr_q);
    wr_live = wr_en && (wr_eff != ADR_IND);
    sts_hit = wr_live && (wr_eff == ADR_STS);
    ptr_hit = wr_live && (wr_eff == ADR_PTR);
  end

  rf_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_hit(ptr_hit),
    .wr_val(wr_data[RF_AW-1:0]), .q(ptr_q)
  );

  rf_status u_sts (
    .clk(clk), .rst_n(rst_n), .wr_hit(sts_hit),
    .wr_hi(wr_data[7:5]), .wr_fl(wr_data[FLAG_N-1:0]),
    .flag_we(flag_we), .flag_val(flag_val),
    .pwr_we(pwr_we), .pwr_val(pwr_val), .q(sts_q)
  );

  rf_store #(.BASE(PLAIN_A), .COUNT(PLAIN_N)) u_plain_lo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_live), .wr_addr(wr_eff),
    .wr_data(wr_data), .rd_addr(rd_eff), .rd_data(lo_d)
  );

  rf_store #(.BASE(PLAIN_B), .COUNT(PLAIN_N)) u_plain_hi (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_live), .wr_addr(wr_eff),
    .wr_data(wr_data), .rd_addr(rd_eff), .rd_data(hi_d)
  );

  rf_store #(.BASE(GPR_BASE), .COUNT(NUM_GPR)) u_gpr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_live), .wr_addr(wr_eff),
    .wr_data(wr_data), .rd_addr(rd_eff), .rd_data(gpr_d)
  );

  always_comb begin
    if (rd_eff == ADR_STS)      rd_data = sts_q;
    else if (rd_eff == ADR_PTR) rd_data = {{PTR_PAD{1'b1}}, ptr_q};
    else                        rd_data = lo_d | hi_d | gpr_d;
  end
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [RF_AW-1:0]  rd_addr,
  input logic [RF_DW-1:0]  rd_data,
  input logic              wr_en,
  input logic [RF_AW-1:0]  wr_addr,
  input logic [FLAG_N-1:0] flag_we,
  input logic [FLAG_N-1:0] flag_val,
  input logic              pwr_we,
  input logic [RF_AW-1:0]  ptr_q,
  input logic [RF_DW-1:0]  sts_q
);
  AST_NULL_PTR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 5'd0 && ptr_q == 5'd0) |-> rd_data == 8'h00); // R4
  AST_NULL_PTR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 5'd0 && ptr_q == 5'd0 && flag_we == 3'b000 && !pwr_we)
      |=> (sts_q == $past(sts_q) && ptr_q == $past(ptr_q))); // R4
  AST_PTR_HIGH_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 5'd4 |-> rd_data[7:5] == 3'b111); // R5
  AST_FIXED_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_we |=> sts_q[4:3] == $past(sts_q[4:3])); // R8
  AST_ZERO_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we[2] |=> sts_q[2] == $past(flag_val[2])); // R7
  AST_CARRY_FLAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we[0] |=> sts_q[0] == $past(flag_val[0])); // R7
  AST_UNBUILT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_addr == 5'd7 |-> rd_data == 8'h00); // R9
endmodule

bind regfile_indirect rf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .flag_we(flag_we), .flag_val(flag_val),
  .pwr_we(pwr_we), .ptr_q(ptr_q), .sts_q(sts_q)
);

// File: tb/regfile_indirect_test.sv
module regfile_indirect_test;
  localparam int NG = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic       wr_en, pwr_we;
  logic [2:0] flag_we, flag_val;
  logic [1:0] pwr_val;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0] m_mem [32];
  logic [4:0] m_ptr;
  logic [7:0] m_sts;

  regfile_indirect #(.NUM_GPR(NG)) uut (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_we(flag_we), .flag_val(flag_val), .pwr_we(pwr_we), .pwr_val(pwr_val)
  );

  always #5 clk = ~clk;

  function automatic bit is_store(input int a);
    return (a == 1) || (a == 2) || (a == 5) || (a == 6) || (a >= 8 && a < 8 + NG);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [4:0] a);
    logic [4:0] e;
    e = (a == 5'd0) ? m_ptr : a;
    if (e == 5'd0) return 8'h00;
    if (e == 5'd3) return m_sts;
    if (e == 5'd4) return {3'b111, m_ptr};
    if (is_store(int'(e))) return m_mem[e];
    return 8'h00;
  endfunction

  function automatic string tag_of(input int a);
    if (a == 0) return "R3";
    if (a == 3) return "R6";
    if (a == 4) return "R5";
    if (is_store(a)) return "R1";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic model_wr(input logic [4:0] a, input logic [7:0] d, input logic [2:0] fwe,
                          input logic [2:0] fv, input logic pwe, input logic [1:0] pv);
    logic [4:0] e;
    logic [7:0] s;
    e = (a == 5'd0) ? m_ptr : a;
    s = m_sts;
    if (e == 5'd3) begin
      s[7:5] = d[7:5];
      if (fwe == 3'b000) s[2:0] = d[2:0];
    end
    for (int i = 0; i < 3; i++) if (fwe[i]) s[i] = fv[i];
    if (pwe) s[4:3] = pv;
    if (e == 5'd4) m_ptr = d[4:0];
    else if (is_store(int'(e))) m_mem[e] = d;
    m_sts = s;
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [7:0] d, input logic [2:0] fwe,
                       input logic [2:0] fv, input logic pwe, input logic [1:0] pv);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    flag_we = fwe; flag_val = fv; pwr_we = pwe; pwr_val = pv;
    @(posedge clk);
    #1;
    wr_en = 1'b0; flag_we = 3'b000; pwr_we = 1'b0;
    model_wr(a, d, fwe, fv, pwe, pv);
  endtask

  task automatic rd_check(input string req, input logic [4:0] a);
    rd_addr = a;
    #1;
    check(req, rd_data, exp_rd(a));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; rd_addr = '0; wr_addr = '0; wr_data = '0; wr_en = 1'b0;
    flag_we = '0; flag_val = '0; pwr_we = 1'b0; pwr_val = '0;
    for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
    m_ptr = 5'd0;
    m_sts = 8'h18;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state (RAM content is undefined and skipped)
    for (int a = 0; a < 32; a++) begin
      if (!(a >= 8 && a < 8 + NG)) rd_check("R10", 5'(a));
    end

    // R1 R5 R6 R8 R9: direct write sweep, then full read sweep
    for (int a = 1; a < 32; a++) do_wr(5'(a), 8'(a * 37 + 5), 3'b000, 3'b000, 1'b0, 2'b00);
    for (int a = 0; a < 32; a++) rd_check(tag_of(a), 5'(a));

    // R2: read of the address under write returns the old value
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd10; wr_data = 8'h3C; rd_addr = 5'd10;
    #1;
    check("R2", rd_data, m_mem[10]);
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    model_wr(5'd10, 8'h3C, 3'b000, 3'b000, 1'b0, 2'b00);
    rd_check("R2", 5'd10);

    // R3 R4: pointer sweep with indirect write and read
    for (int p = 0; p < 32; p++) begin
      do_wr(5'd4, 8'(8'h40 | p), 3'b000, 3'b000, 1'b0, 2'b00);
      rd_check("R5", 5'd4);
      do_wr(5'd0, 8'(8'hA0 + p), 3'b000, 3'b000, 1'b0, 2'b00);
      rd_check(p == 0 ? "R4" : "R3", 5'd0);
      rd_check(p == 0 ? "R4" : tag_of(p), 5'(p));
      rd_check("R4", 5'd3);
    end

    // R7: status write against every flag enable and value combination
    for (int e = 0; e < 8; e++) begin
      for (int v = 0; v < 8; v++) begin
        do_wr(5'd3, 8'((e * 8 + v) ^ 8'hA5), 3'(e), 3'(v), 1'b0, 2'b00);
        rd_check("R7", 5'd3);
      end
    end

    // R7: flag update while writing elsewhere
    do_wr(5'd9, 8'h11, 3'b011, 3'b010, 1'b0, 2'b00);
    rd_check("R7", 5'd3);
    rd_check("R1", 5'd9);

    // R7: clear with only Z enabled gives 000uu1uu
    do_wr(5'd3, 8'hFF, 3'b000, 3'b000, 1'b0, 2'b00);
    do_wr(5'd3, 8'h00, 3'b100, 3'b100, 1'b0, 2'b00);
    rd_addr = 5'd3;
    #1;
    check("R7", rd_data, 8'h1F);

    // R8: fixed bits load only from the power port
    do_wr(5'd12, 8'h00, 3'b000, 3'b000, 1'b1, 2'b01);
    rd_check("R8", 5'd3);
    do_wr(5'd3, 8'hFF, 3'b000, 3'b000, 1'b0, 2'b00);
    rd_addr = 5'd3;
    #1;
    check("R8", rd_data, 8'hEF);
    do_wr(5'd3, 8'h00, 3'b000, 3'b000, 1'b1, 2'b10);
    rd_check("R8", 5'd3);

    // R9: unbuilt location stays zero after a write
    do_wr(5'd7, 8'h5A, 3'b000, 3'b000, 1'b0, 2'b00);
    rd_check("R9", 5'd7);
    do_wr(5'd31, 8'h5A, 3'b000, 3'b000, 1'b0, 2'b00);
    rd_check("R9", 5'd31);

    done = 1'b1;
    finish_run();
  end
endmodule